// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller

This block gathers eleven interrupt sources for a small controller core: one supply-sense pin that reports loss of the accessory supply, four general pins whose active edge software selects one pin at a time, and six single-cycle request pulses from on-chip peripherals (two serial channels and four timers). Each source latches a pending flag. A separate enable mask decides which pending flags may be presented to the core. The pins pass through a two-stage synchronizer before their edges are detected. The supply-sense pin reacts only to a falling level and also sets a sticky status bit.

The core sees one registered request line and a vector index: the enabled pending source with the highest fixed priority. Accepting the request with `irq_ack` clears that flag and pushes the source onto an in-service set. `irq_ret` retires the most urgent in-service source. While a handler runs, only a strictly more urgent source may interrupt it, so nesting can reach the full source count. A small write-only register port sets the enable mask and the edge polarities, clears flags, and clears the supply status.

Top module: `irqc_top`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0, `nest_depth` is 0 and `supply_lost` is 0.
- R2: Vector indices follow priority, lowest index most urgent: 0 supply pin, 1..4 `pin_ext[0..3]`, 5..6 `int_pulse[0..1]` (serial), 7..10 `int_pulse[2..5]` (timers). When several enabled sources are pending, `irq_vec` shows the lowest index.
- R3: Register 1 bit i selects the active edge of `pin_ext[i]`: 1 rising, 0 falling (reset value 0). An edge of the other polarity raises no request.
- R4: The supply pin raises a request on a falling edge only; a rising edge has no effect.
- R5: A supply falling edge sets `supply_lost` as well as pending flag 0. Acknowledging does not clear `supply_lost`; only writing 1 to bit 0 of register 3 does.
- R6: Register 0 holds the enable mask, one bit per index. A pending flag whose enable bit is 0 is kept, and it is presented in the cycle after the enable is written.
- R7: `irq_ack` while `irq_req` is high clears the flag of `irq_vec`, marks that source in service, and raises `nest_depth` by one.
- R8: While sources are in service, a request is presented only when its index is strictly lower than every in-service index. Equal or lower-priority requests wait.
- R9: `irq_ret` retires the in-service source with the lowest index and lowers `nest_depth` by one. A waiting request is then presented in the next cycle.
- R10: Writing register 2 clears every pending flag whose data bit is 1.
- R11: A selected pin edge makes `irq_req` rise three clock edges after the pin changes, and not earlier.
- R12: An `int_pulse` bit high at one clock edge makes `irq_req` visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_supply | input | 1 | Supply-sense pin, asynchronous, idle high |
| pin_ext | input | 4 | General interrupt pins, asynchronous |
| int_pulse | input | 6 | Single-cycle internal request pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 edge, 2 clear, 3 status clear |
| reg_wdata | input | 11 | Register write data |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 4 | Index of the presented source |
| nest_depth | output | 4 | Number of sources in service |
| supply_lost | output | 1 | Sticky supply-loss status |

## Verification
The assertions assume that the core pulses `irq_ack` only while `irq_req` is high, and that it raises `irq_ret` only when a handler is active. The bench keeps to this because every acknowledge follows a check that a request is presented, and every return matches an earlier acknowledge. The bench drives the pins at least five cycles apart, so the synchronizer never sees a glitch shorter than a cycle. Internal pulses last exactly one cycle each.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int EXT_PINS  = 4;
  localparam int INT_SRCS  = 6;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_EDGE   = 2'd1,
    REG_CLEAR  = 2'd2,
    REG_STATUS = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_edge.sv
`timescale 1ns/1ps
module irqc_edge #(
  parameter bit IDLE_HIGH = 1'b0,
  parameter bit FALL_ONLY = 1'b0,
  parameter int STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic evt
);
  // shift chain: [STAGES-1] is the synchronized level, [STAGES] the previous one
  logic [STAGES:0] chain_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {(STAGES+1){IDLE_HIGH}};
    else     chain_q <= {chain_q[STAGES-1:0], pin};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];
  assign evt  = (rise_sel && !FALL_ONLY) ? rise : fall;
endmodule

// File: rtl/irqc_flags.sv
`timescale 1ns/1ps
module irqc_flags #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pend_nxt,
  output logic [N-1:0] pend_q
);
  // a new event in the same cycle as a clear wins, so no edge is lost
  assign pend_nxt = (pend_q & ~clr_mask) | set_ev;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ((clr_mask & ~set_ev) != '0) |=> ((pend_q & $past(clr_mask & ~set_ev)) == '0)); // R10

  AST_EVENT_HELD: assert property (@(posedge clk) disable iff (rst)
    (set_ev != '0) |=> ((pend_q & $past(set_ev)) == $past(set_ev))); // R6
endmodule

// File: rtl/irqc_arb.sv
`timescale 1ns/1ps
module irqc_arb #(
  parameter int N  = 11,
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend_nxt,
  input  logic [N-1:0]  en_nxt,
  input  logic          ack,
  input  logic          ret,
  output logic          req_q,
  output logic [VW-1:0] vec_q,
  output logic [VW-1:0] depth_q
);
  localparam logic [VW-1:0] NONE = VW'(N);

  function automatic logic [VW-1:0] first_idx(input logic [N-1:0] v);
    logic [VW-1:0] r;
    r = NONE;
    for (int i = N-1; i >= 0; i--) if (v[i]) r = VW'(i);
    return r;
  endfunction

  function automatic logic [VW-1:0] pop_count(input logic [N-1:0] v);
    logic [VW-1:0] c;
    c = '0;
    for (int i = 0; i < N; i++) c = c + VW'(v[i]);
    return c;
  endfunction

  logic [N-1:0]  inserv_q, inserv_nxt, after_ret, one_hot_top, cand;
  logic [VW-1:0] level_nxt, cand_idx, level_q;
  logic          req_nxt;

  always_comb begin
    one_hot_top = '0;
    if (first_idx(inserv_q) != NONE) one_hot_top[first_idx(inserv_q)] = 1'b1;
    after_ret  = ret ? (inserv_q & ~one_hot_top) : inserv_q;
    inserv_nxt = after_ret;
    if (ack) inserv_nxt[vec_q] = 1'b1;
    cand      = pend_nxt & en_nxt;
    cand_idx  = first_idx(cand);
    level_nxt = first_idx(inserv_nxt);
    req_nxt   = (cand != '0) && (cand_idx < level_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inserv_q <= '0;
      req_q    <= 1'b0;
      vec_q    <= '0;
      depth_q  <= '0;
    end else begin
      inserv_q <= inserv_nxt;
      req_q    <= req_nxt;
      vec_q    <= req_nxt ? cand_idx : '0;
      depth_q  <= pop_count(inserv_nxt);
    end
  end

  assign level_q = first_idx(inserv_q);

  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (rst)
    (req_q && inserv_q != '0) |-> (vec_q < level_q)); // R8

  AST_DEPTH_UP: assert property (@(posedge clk) disable iff (rst)
    (ack && !ret) |=> (depth_q == VW'($past(depth_q) + 1'b1))); // R7

  AST_DEPTH_DOWN: assert property (@(posedge clk) disable iff (rst)
    (ret && !ack && depth_q != '0) |=> (depth_q == VW'($past(depth_q) - 1'b1))); // R9
endmodule

// File: rtl/irqc_top.sv
`timescale 1ns/1ps
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_EXT  = EXT_PINS,
  parameter int N_INT  = INT_SRCS,
  parameter int SYNC_N = SYNC_DEPTH,
  localparam int SRC_N = 1 + N_EXT + N_INT,
  localparam int VW    = $clog2(SRC_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_supply,
  input  logic [N_EXT-1:0] pin_ext,
  input  logic [N_INT-1:0] int_pulse,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [SRC_N-1:0] reg_wdata,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VW-1:0]    irq_vec,
  output logic [VW-1:0]    nest_depth,
  output logic             supply_lost
);
  logic [SRC_N-1:0] src_ev, en_q, en_nxt, clr_mask, ack_mask, pend_nxt, pend_q;
  logic [N_EXT-1:0] edge_q;
  logic             supply_q, ack_ok;
  logic             wr_en, wr_edge, wr_clr, wr_stat;
  logic             unused_bits;

  assign wr_en   = reg_we && (reg_addr == REG_ENABLE);
  assign wr_edge = reg_we && (reg_addr == REG_EDGE);
  assign wr_clr  = reg_we && (reg_addr == REG_CLEAR);
  assign wr_stat = reg_we && (reg_addr == REG_STATUS);
  assign unused_bits = ^pend_q;

  // source 0: supply pin, idle high, falling edge only
  irqc_edge #(.IDLE_HIGH(1'b1), .FALL_ONLY(1'b1), .STAGES(SYNC_N)) u_supply (
    .clk(clk), .rst(rst), .pin(pin_supply), .rise_sel(1'b0), .evt(src_ev[0])
  );

  // sources 1..N_EXT: pins with selectable polarity
  for (genvar g = 0; g < N_EXT; g++) begin : g_pin
    irqc_edge #(.IDLE_HIGH(1'b0), .FALL_ONLY(1'b0), .STAGES(SYNC_N)) u_edge (
      .clk(clk), .rst(rst), .pin(pin_ext[g]), .rise_sel(edge_q[g]),
      .evt(src_ev[1+g])
    );
  end

  // remaining sources: internal pulses in priority order
  assign src_ev[SRC_N-1:1+N_EXT] = int_pulse;

  assign en_nxt   = wr_en ? reg_wdata : en_q;
  assign ack_ok   = irq_ack && irq_req;
  assign ack_mask = ack_ok ? (SRC_N'(1) << irq_vec) : '0;
  assign clr_mask = (wr_clr ? reg_wdata : '0) | ack_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      edge_q   <= '0;
      supply_q <= 1'b0;
    end else begin
      en_q <= en_nxt;
      if (wr_edge) edge_q <= reg_wdata[N_EXT-1:0];
      if (src_ev[0])                   supply_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) supply_q <= 1'b0;
    end
  end

  irqc_flags #(.N(SRC_N)) u_flags (
    .clk(clk), .rst(rst), .set_ev(src_ev), .clr_mask(clr_mask),
    .pend_nxt(pend_nxt), .pend_q(pend_q)
  );

  irqc_arb #(.N(SRC_N), .VW(VW)) u_arb (
    .clk(clk), .rst(rst), .pend_nxt(pend_nxt), .en_nxt(en_nxt),
    .ack(ack_ok), .ret(irq_ret), .req_q(irq_req), .vec_q(irq_vec),
    .depth_q(nest_depth)
  );

  assign supply_lost = supply_q;

  AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> en_q[irq_vec]); // R6

  AST_SUPPLY_STICKY: assert property (@(posedge clk) disable iff (rst)
    (supply_lost && !(wr_stat && reg_wdata[0])) |=> supply_lost); // R5

  AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> irq_req); // R7
endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        pin_supply;
  logic [3:0]  pin_ext;
  logic [5:0]  int_pulse;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [10:0] reg_wdata;
  logic        irq_ack, irq_ret;
  logic        irq_req;
  logic [3:0]  irq_vec, nest_depth;
  logic        supply_lost;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst(rst), .pin_supply(pin_supply), .pin_ext(pin_ext),
    .int_pulse(int_pulse), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .nest_depth(nest_depth),
    .supply_lost(supply_lost)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [10:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [5:0] m);
    int_pulse = m;
    tick();
    int_pulse = '0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req", irq_req, 0);
    check("R1 depth", nest_depth, 0);
    check("R1 supply_lost", supply_lost, 0);
  endtask

  task automatic t_internal();
    wr(2'd0, 11'h7FF);
    pulse(6'b000100);
    check("R12 req after one edge", irq_req, 1);
    check("R12 vec timer0", irq_vec, 7);
    ack();
    check("R7 depth after ack", nest_depth, 1);
    check("R7 flag cleared", irq_req, 0);
    ret();
    check("R9 depth after ret", nest_depth, 0);
  endtask

  task automatic t_priority();
    pulse(6'b100001);
    check("R2 lowest index wins", irq_vec, 5);
    ack();
    check("R8 lower waits", irq_req, 0);
    ret();
    check("R9 waiting req shown", irq_req, 1);
    check("R9 waiting vec", irq_vec, 10);
    ack(); ret();
    check("R9 idle", nest_depth, 0);
  endtask

  task automatic t_nesting();
    pulse(6'b100000);
    ack();
    check("R7 depth1", nest_depth, 1);
    pulse(6'b000001);
    check("R8 higher preempts req", irq_req, 1);
    check("R8 higher preempts vec", irq_vec, 5);
    ack();
    check("R7 depth2", nest_depth, 2);
    pulse(6'b000001);
    check("R8 equal not presented", irq_req, 0);
    ret();
    check("R9 pop to depth1", nest_depth, 1);
    check("R9 pending shown after pop", irq_vec, 5);
    check("R9 pending req after pop", irq_req, 1);
    ack(); ret(); ret();
    check("R9 depth back to zero", nest_depth, 0);
    check("R9 nothing left", irq_req, 0);
  endtask

  task automatic t_pins();
    wr(2'd1, 11'b0101);
    pin_ext[0] = 1'b1;
    tick(2);
    check("R11 not yet after two edges", irq_req, 0);
    tick();
    check("R11 req after three edges", irq_req, 1);
    check("R3 pin0 rising vec", irq_vec, 1);
    ack(); ret();
    pin_ext[0] = 1'b0;
    tick(5);
    check("R3 pin0 falling ignored", irq_req, 0);
    pin_ext[1] = 1'b1;
    tick(5);
    check("R3 pin1 rising ignored", irq_req, 0);
    pin_ext[1] = 1'b0;
    tick(5);
    check("R3 pin1 falling req", irq_req, 1);
    check("R3 pin1 falling vec", irq_vec, 2);
    ack(); ret();
  endtask

  task automatic t_supply();
    pin_supply = 1'b0;
    tick(5);
    check("R4 falling req", irq_req, 1);
    check("R4 falling vec", irq_vec, 0);
    check("R5 status set", supply_lost, 1);
    ack(); ret();
    check("R5 status kept after ack", supply_lost, 1);
    pin_supply = 1'b1;
    tick(5);
    check("R4 rising ignored", irq_req, 0);
    wr(2'd3, 11'd1);
    check("R5 status cleared", supply_lost, 0);
  endtask

  task automatic t_enable();
    wr(2'd0, 11'h000);
    pulse(6'b001000);
    check("R6 disabled not shown", irq_req, 0);
    tick(3);
    check("R6 still hidden", irq_req, 0);
    wr(2'd0, 11'h7FF);
    check("R6 shown once enabled", irq_req, 1);
    check("R6 kept vec", irq_vec, 8);
    ack(); ret();
  endtask

  task automatic t_clear();
    wr(2'd0, 11'h000);
    pulse(6'b010000);
    wr(2'd2, 11'h200);
    wr(2'd0, 11'h7FF);
    check("R10 cleared while hidden", irq_req, 0);
    pulse(6'b010000);
    check("R10 shown vec", irq_vec, 9);
    wr(2'd2, 11'h200);
    check("R10 cleared while shown", irq_req, 0);
  endtask

  initial begin
    rst = 1'b1; pin_supply = 1'b1; pin_ext = '0; int_pulse = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_ack = 1'b0; irq_ret = 1'b0;
    tick(3);
    rst = 1'b0;
    tick();
    t_reset();
    t_internal();
    t_priority();
    t_nesting();
    t_pins();
    t_supply();
    t_enable();
    t_clear();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule